// File: doc/BRIEF.md
# Paired PWM Clock Source Divider

This block makes the common time base for two PWM channels that work as a pair. It picks one of two source tick streams: a slow oscillator-rate tick, or a bus-rate tick that is normally high on every cycle. It divides the picked stream by a power of two, from 1 to 256. The result is a single-cycle clock-enable pulse in the system clock domain. No derived clock is produced. Both channels of the pair always see the same source and the same division ratio. Each channel's pulse then passes through that channel's own clock gate and its own enable bit before it reaches the channel's prescaler and counter, which sit outside this block.

When either the source choice or the divide exponent changes, the divider count starts over from zero. The first pulse under the new setting therefore comes only after a full new period, never as a short runt. Exponent values above the largest supported one are clamped to it.

Top module: `pwmpair_clkdiv`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pair_tick_o` and both bits of `chan_tick_o` are low.
- R2: `src_sel_i` is a 2-bit source code. Code 0 selects `src_tick_i[0]`, the oscillator tick. Code 1 selects `src_tick_i[1]`, the bus tick. Only ticks of the selected source advance the divider.
- R3: Source codes 2 and 3 select no source, and no pulse is produced while either one is held.
- R4: With a steady setting, `pair_tick_o` is high for exactly one cycle per 2^M selected ticks, where M is `div_m_i`. The pulse appears in the cycle after the tick that completes the count.
- R5: A value of `div_m_i` above 8 behaves exactly like 8, giving a ratio of 256.
- R6: In the cycle that follows a change of `src_sel_i` or `div_m_i`, no pulse is produced and the count restarts. With the bus source held at one, the first new pulse is seen 2^M + 1 cycles after the change is applied.
- R7: When `gate_i[n]` is low, `chan_tick_o[n]` stays low whatever `chan_en_i[n]` says.
- R8: When `chan_en_i[n]` is low, `chan_tick_o[n]` stays low even with its gate open.
- R9: With gate and enable both set for both channels, the two channel ticks are identical on every cycle and equal to `pair_tick_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_tick_i | input | 2 | Source tick streams: bit 0 oscillator, bit 1 bus |
| src_sel_i | input | 2 | Source code (0 oscillator, 1 bus, 2 and 3 none) |
| div_m_i | input | 4 | Divide exponent M; ratio 2^M, clamped at 8 |
| gate_i | input | 2 | Per-channel clock gate |
| chan_en_i | input | 2 | Per-channel enable |
| pair_tick_o | output | 1 | Shared divided clock-enable pulse |
| chan_tick_o | output | 2 | Gated and enabled per-channel tick |

## Verification
The hardest case to reach is a setting change that lands while a count is partly done, or right after a pulse. That is the case where a runt pulse would appear. The bench first lets the divider run under one setting and then applies a new exponent or source on a falling edge. It counts the cycles to the first pulse under the new setting and compares the count with 2^M + 1. It does this for a shrinking ratio, for a source swap, and for a change down to ratio 1. The clamp is checked by measuring the gap between pulses for exponents 9 and 15. Both must give 256.

// File: rtl/pwmpair_pkg.sv
package pwmpair_pkg;

   // Default geometry of the pair clock configuration
   localparam int unsigned PP_NUM_SRC = 2;
   localparam int unsigned PP_SEL_W   = 2;
   localparam int unsigned PP_M_W     = 4;
   localparam int unsigned PP_M_MAX   = 8;
   localparam int unsigned PP_NUM_CH  = 2;

   // Source codes carried by the select field
   typedef enum logic [PP_SEL_W-1:0] {
      PP_SRC_OSC  = 2'd0,
      PP_SRC_BUS  = 2'd1,
      PP_SRC_NONE2 = 2'd2,
      PP_SRC_NONE3 = 2'd3
   } pp_src_e;

   // Clamp an exponent request to the largest supported value
   function automatic int unsigned pp_clamp(input int unsigned req,
                                            input int unsigned lim);
      return (req > lim) ? lim : req;
   endfunction

endpackage

// File: rtl/pwmpair_src_mux.sv
module pwmpair_src_mux #(
   parameter int unsigned NUM_SRC = pwmpair_pkg::PP_NUM_SRC,
   parameter int unsigned SEL_W   = pwmpair_pkg::PP_SEL_W
) (
   input  logic [NUM_SRC-1:0] src_tick_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               tick_o
);

   localparam int unsigned NUM_CODE = 1 << SEL_W;

   if (NUM_SRC > NUM_CODE) begin : g_bad_src
      $error("pwmpair_src_mux: NUM_SRC does not fit in the select field");
   end

   // One hit bit per legal source; codes past NUM_SRC select nothing
   logic [NUM_SRC-1:0] hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
      assign hit[s] = src_tick_i[s] && (sel_i == SEL_W'(s));
   end

   assign tick_o = |hit;

endmodule

// File: rtl/pwmpair_pow2_div.sv
module pwmpair_pow2_div #(
   parameter int unsigned SEL_W = pwmpair_pkg::PP_SEL_W,
   parameter int unsigned M_W   = pwmpair_pkg::PP_M_W,
   parameter int unsigned M_MAX = pwmpair_pkg::PP_M_MAX
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [M_W-1:0]   m_i,
   output logic             pulse_o
);

   localparam int unsigned CNT_W   = (M_MAX < 1) ? 1 : M_MAX;
   localparam int unsigned M_CODES = 1 << M_W;

   if (M_MAX >= M_CODES) begin : g_bad_m
      $error("pwmpair_pow2_div: M_MAX does not fit in the exponent field");
   end
   if (M_MAX > 16) begin : g_bad_depth
      $error("pwmpair_pow2_div: M_MAX above 16 makes an oversized counter");
   end

   // Exponent after the clamp; pass-through when the field cannot exceed M_MAX
   logic [M_W-1:0] m_eff;

   if (M_CODES - 1 > M_MAX) begin : g_clamp
      assign m_eff = M_W'(pwmpair_pkg::pp_clamp(int'(m_i), M_MAX));
   end else begin : g_noclamp
      assign m_eff = m_i;
   end

   // Registered copy of the setting, used to detect a change
   logic [SEL_W-1:0] sel_q;
   logic [M_W-1:0]   m_q;
   logic             cfg_change;

   assign cfg_change = (sel_i != sel_q) || (m_eff != m_q);

   // Terminal count for the active exponent: 2^M - 1
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] limit;

   assign span  = {{CNT_W{1'b0}}, 1'b1} << m_eff;
   assign limit = CNT_W'(span - 1'b1);

   logic [CNT_W-1:0] cnt_q;
   logic             pulse_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sel_q   <= '0;
         m_q     <= '0;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         sel_q <= sel_i;
         m_q   <= m_eff;
         if (cfg_change) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
         end else if (tick_i) begin
            if (cnt_q == limit) begin
               cnt_q   <= '0;
               pulse_q <= 1'b1;
            end else begin
               cnt_q   <= cnt_q + 1'b1;
               pulse_q <= 1'b0;
            end
         end else begin
            pulse_q <= 1'b0;
         end
      end
   end

   assign pulse_o = pulse_q;

   // Terminal count of the registered exponent, for the checks below
   logic [CNT_W:0]   span_q;
   logic [CNT_W-1:0] limit_q;

   assign span_q  = {{CNT_W{1'b0}}, 1'b1} << m_q;
   assign limit_q = CNT_W'(span_q - 1'b1);

   // R4: the count never passes the terminal value of the setting in force
   a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= limit_q);

   // R4: with a ratio above one, a pulse is never followed by another at once
   a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_q && (m_q != '0)) |=> !pulse_q);

   // R6: a setting change yields no pulse in the following cycle
   a_r6_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_change |=> !pulse_q);

   // R2: a pulse needs a selected tick in the previous cycle
   a_r2_pulse_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q |-> $past(tick_i));

endmodule

// File: rtl/pwmpair_chan_gate.sv
module pwmpair_chan_gate (
   input  logic pair_tick_i,
   input  logic gate_i,
   input  logic en_i,
   output logic tick_o
);

   // The gate is the outer control: with it closed the enable has no effect
   logic gated;

   assign gated  = pair_tick_i && gate_i;
   assign tick_o = gated && en_i;

endmodule

// File: rtl/pwmpair_clkdiv.sv
module pwmpair_clkdiv #(
   parameter int unsigned NUM_SRC = pwmpair_pkg::PP_NUM_SRC,
   parameter int unsigned SEL_W   = pwmpair_pkg::PP_SEL_W,
   parameter int unsigned M_W     = pwmpair_pkg::PP_M_W,
   parameter int unsigned M_MAX   = pwmpair_pkg::PP_M_MAX,
   parameter int unsigned NUM_CH  = pwmpair_pkg::PP_NUM_CH
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_tick_i,
   input  logic [SEL_W-1:0]   src_sel_i,
   input  logic [M_W-1:0]     div_m_i,
   input  logic [NUM_CH-1:0]  gate_i,
   input  logic [NUM_CH-1:0]  chan_en_i,
   output logic               pair_tick_o,
   output logic [NUM_CH-1:0]  chan_tick_o
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwmpair_clkdiv: at least one channel is needed");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("pwmpair_clkdiv: at least one source is needed");
   end

   logic sel_tick;
   logic div_pulse;

   pwmpair_src_mux #(
      .NUM_SRC (NUM_SRC),
      .SEL_W   (SEL_W)
   ) u_mux (
      .src_tick_i (src_tick_i),
      .sel_i      (src_sel_i),
      .tick_o     (sel_tick)
   );

   pwmpair_pow2_div #(
      .SEL_W (SEL_W),
      .M_W   (M_W),
      .M_MAX (M_MAX)
   ) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (sel_tick),
      .sel_i   (src_sel_i),
      .m_i     (div_m_i),
      .pulse_o (div_pulse)
   );

   assign pair_tick_o = div_pulse;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwmpair_chan_gate u_gate (
         .pair_tick_i (div_pulse),
         .gate_i      (gate_i[c]),
         .en_i        (chan_en_i[c]),
         .tick_o      (chan_tick_o[c])
      );

      // R9: a channel tick only ever comes from the shared divider pulse
      a_r9_from_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
         chan_tick_o[c] |-> div_pulse);

      // R7: a closed gate keeps the channel tick low
      a_r7_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !gate_i[c] |-> !chan_tick_o[c]);
   end

   // R3: a select code with no source keeps the shared pulse low once settled
   a_r3_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((src_sel_i >= SEL_W'(NUM_SRC)) && $stable(src_sel_i)) |=> !pair_tick_o);

endmodule

// File: tb/pwmpair_clkdiv_bench.sv
module pwmpair_clkdiv_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic [1:0] src_sel = 2'd1;
   logic [3:0] div_m = 4'd0;
   logic [1:0] gate = 2'b11;
   logic [1:0] en = 2'b11;
   logic       pair_tick;
   logic [1:0] chan_tick;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   pwmpair_clkdiv u_pwmpair_clkdiv (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .src_tick_i  ({1'b1, osc_tick}),
      .src_sel_i   (src_sel),
      .div_m_i     (div_m),
      .gate_i      (gate),
      .chan_en_i   (en),
      .pair_tick_o (pair_tick),
      .chan_tick_o (chan_tick)
   );

   // Oscillator-rate tick: high on one cycle out of three
   initial begin
      int phase = 0;
      forever begin
         @(negedge clk);
         phase = (phase + 1) % 3;
         osc_tick = (phase == 0);
      end
   end

   // Watchdog
   initial begin
      forever begin
         @(negedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Cycles until chan_tick[ch] is seen high (bit 2 means pair_tick)
   task automatic wait_pulse(input int ch, output int n);
      logic seen;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         seen = (ch == 2) ? pair_tick : chan_tick[ch];
      end while (!seen && n < 2000);
   endtask

   task automatic meas_gap(input int ch, output int gap);
      int dummy;
      wait_pulse(ch, dummy);
      wait_pulse(ch, gap);
   endtask

   task automatic count_pulses(input int len, output int c0, output int c1,
                               output int cp);
      c0 = 0; c1 = 0; cp = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         c0 += int'(chan_tick[0]);
         c1 += int'(chan_tick[1]);
         cp += int'(pair_tick);
      end
   endtask

   task automatic t_reset;
      int c0, c1, cp;
      rst_n = 1'b0;
      src_sel = 2'd1; div_m = 4'd0; gate = 2'b11; en = 2'b11;
      count_pulses(5, c0, c1, cp);
      chk("R1 pulses during reset", cp + c0 + c1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first cycle after reset", int'(pair_tick) + int'(chan_tick[0]), 0);
   endtask

   task automatic t_divide;
      int gap;
      src_sel = 2'd1;
      div_m = 4'd0; meas_gap(0, gap); chk("R4 bus M=0 gap", gap, 1);
      div_m = 4'd1; meas_gap(0, gap); chk("R4 bus M=1 gap", gap, 2);
      div_m = 4'd3; meas_gap(0, gap); chk("R4 bus M=3 gap", gap, 8);
      div_m = 4'd8; meas_gap(0, gap); chk("R4 bus M=8 gap", gap, 256);
   endtask

   task automatic t_osc;
      int gap;
      src_sel = 2'd0;
      div_m = 4'd0; meas_gap(2, gap); chk("R2 osc M=0 gap", gap, 3);
      div_m = 4'd2; meas_gap(2, gap); chk("R2 osc M=2 gap", gap, 12);
   endtask

   task automatic t_reserved;
      int c0, c1, cp, n;
      div_m = 4'd0;
      src_sel = 2'd2;
      count_pulses(40, c0, c1, cp);
      chk("R3 code 2 pulses", cp + c0 + c1, 0);
      src_sel = 2'd3;
      count_pulses(40, c0, c1, cp);
      chk("R3 code 3 pulses", cp + c0 + c1, 0);
      src_sel = 2'd1;
      wait_pulse(2, n);
      chk("R2 bus resumes after code 3", n, 2);
   endtask

   task automatic t_clamp;
      int gap;
      src_sel = 2'd1;
      div_m = 4'd9;  meas_gap(0, gap); chk("R5 M=9 gap", gap, 256);
      div_m = 4'd15; meas_gap(0, gap); chk("R5 M=15 gap", gap, 256);
   endtask

   task automatic t_restart;
      int n, dummy;
      src_sel = 2'd1; div_m = 4'd3;
      wait_pulse(0, dummy);
      repeat (3) @(negedge clk);
      div_m = 4'd2;
      wait_pulse(0, n);
      chk("R6 M 3->2 first pulse", n, 5);
      src_sel = 2'd0; div_m = 4'd4;
      wait_pulse(2, dummy);
      src_sel = 2'd1;
      wait_pulse(2, n);
      chk("R6 source swap M=4 first pulse", n, 17);
      div_m = 4'd8;
      wait_pulse(2, dummy);
      repeat (7) @(negedge clk);
      div_m = 4'd0;
      wait_pulse(2, n);
      chk("R6 M 8->0 first pulse", n, 2);
   endtask

   task automatic t_gate_en;
      int c0, c1, cp;
      src_sel = 2'd1; div_m = 4'd0;
      gate = 2'b10; en = 2'b11;
      count_pulses(40, c0, c1, cp);
      chk("R7 gate0 closed ch0", c0, 0);
      chk("R7 gate0 closed ch1 runs", c1, 40);
      gate = 2'b11; en = 2'b01;
      count_pulses(40, c0, c1, cp);
      chk("R8 en1 low ch1", c1, 0);
      chk("R8 en1 low ch0 runs", c0, 40);
      gate = 2'b00; en = 2'b11;
      count_pulses(40, c0, c1, cp);
      chk("R7 both gates closed", c0 + c1, 0);
      gate = 2'b11;
   endtask

   task automatic t_shared;
      int mism = 0;
      int cnt = 0;
      src_sel = 2'd1; div_m = 4'd2; gate = 2'b11; en = 2'b11;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (chan_tick[0] != chan_tick[1] || chan_tick[0] != pair_tick) mism++;
         cnt += int'(chan_tick[0]);
      end
      chk("R9 channel ticks differ", mism, 0);
      chk("R9 pulses in 64 cycles at ratio 4", cnt, 16);
   endtask

   task automatic t_midreset;
      int c0, c1, cp;
      src_sel = 2'd1; div_m = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      count_pulses(3, c0, c1, cp);
      chk("R1 reset while running", cp + c0 + c1, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_divide();
      t_osc();
      t_reserved();
      t_clamp();
      t_restart();
      t_gate_en();
      t_shared();
      t_midreset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule